// File: doc/BRIEF.md
# TLB Maintenance Command Controller

This block keeps two small translation buffers, one for instruction fetches and one for data accesses, and runs maintenance commands on them under software control. Software loads an address register, an address-space ID register, and two holding registers for entry tag and entry data. It then writes a command word, and the controller performs one operation in the cycle after the write. The operation is a probe search, a class-selective invalidate, a single-entry read or write, or an advance of the round-robin allocation pointer. Results go back to the holding registers, the search-hit flag and the allocation index.

The controller is a two-state machine. In IDLE it waits for a command write. The transition IDLE→EXEC (command write) latches the decoded operation and the three configuration bits. In EXEC the chosen operation is applied to the arrays and to the result registers. The transition EXEC→IDLE is unconditional, and `done` pulses for one cycle after it.

Each buffer holds 8 entries. Every entry has a valid bit, a lock bit, an 8-bit ASID, a 20-bit page tag and a 24-bit data word.

Top module: `tlb_maint_ctrl`

## Requirements
- R1: After reset, every entry in both buffers reads back as all zeros. `alloc_idx`, `srch_hit`, `done` and `cmd_rdata` are all 0.
- R2: The command word bit positions are: bit 8 search, bit 7 clear-all, bit 6 clear-unlocked, bit 5 clear-by-ASID, bit 4 buffer select, bit 3 index select, bit 2 read select, bit 1 access, bit 0 update-allocation. `cmd_rdata` returns bits 4, 3 and 2 from the last write and reads 0 in every strobe position.
- R3: A command written on clock edge N takes effect at edge N+1. `done` is high for exactly the one cycle after edge N+1, and is low in the cycle between the two edges.
- R4: Clear-all sets every field of every tag entry in both buffers to zero, including the lock bits. It also returns both round-robin pointers to entry 0.
- R5: Clear-unlocked invalidates, in both buffers, every entry whose lock bit is 0. Locked entries are left intact.
- R6: Clear-by-ASID invalidates, in both buffers, only the entries that are unlocked and whose ASID equals the ASID register.
- R7: A search hits on a valid entry whose tag equals `ar[19:0]` and whose ASID equals the ASID register. On a hit it sets `srch_hit` and loads `alloc_idx` with the lowest matching index. On a miss it clears `srch_hit` and leaves `alloc_idx` unchanged.
- R8: Select bit 4 picks the target buffer for search, access and update-allocation: 0 selects the data buffer and 1 selects the instruction buffer. The other buffer is not touched.
- R9: Access with read select 1 loads the holding registers from the entry. With read select 0 it writes the holding registers into the entry. The entry index is `alloc_idx` when the index-select bit is 0, and `ar[2:0]` when it is 1. The tag word layout is bit 0 valid, bit 1 lock, bits 9:2 ASID and bits 29:10 tag.
- R10: Update-allocation sets `alloc_idx` to the first unlocked entry of the selected buffer, searching from that buffer's pointer upward and wrapping. It then moves the pointer to the entry after the one chosen. If all 8 entries are locked, `alloc_idx` and the pointer stay unchanged.
- R11: When several strobes are set in one write, only the highest-priority one runs. The order from highest to lowest is: clear-all, clear-unlocked, clear-by-ASID, search, access, update-allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 9 | Command word |
| cmd_rdata | output | 9 | Command register readback |
| ar_we | input | 1 | Address register write strobe |
| ar_wdata | input | 20 | Probe tag or entry index |
| asid_we | input | 1 | ASID register write strobe |
| asid_wdata | input | 8 | Current address-space ID |
| tr_we | input | 1 | Tag holding register write strobe |
| tr_wdata | input | 30 | Tag holding register write value |
| tr_rdata | output | 30 | Tag holding register contents |
| dr_we | input | 1 | Data holding register write strobe |
| dr_wdata | input | 24 | Data holding register write value |
| dr_rdata | output | 24 | Data holding register contents |
| alloc_idx | output | 3 | Allocation index |
| srch_hit | output | 1 | Result of last search |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench gives two matching entries in one buffer and checks that a search reports the lower index. A design that let the last match win would report the higher one. It checks that a miss leaves the allocation index unchanged, and that a matching tag under the wrong ASID also misses; a design without the ASID compare would hit there. It runs round-robin allocation across locked holes, through the wrap, and into a fully locked buffer. A design that did not skip locks, did not wrap, or moved on when nothing was free would return the wrong index. The clear tests use mixed lock and ASID patterns, and the priority tests combine strobes. Together they catch a lock bit that does not protect its entry, a clear-all that leaves the pointers where they were, and a lower-priority strobe that runs as well as, or instead of, the winning one.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;
    localparam int TAG_W  = 20;
    localparam int ASID_W = 8;
    localparam int DATA_W = 24;
    localparam int N_ENT  = 8;
    localparam int IDX_W  = $clog2(N_ENT);
    localparam int TR_W   = TAG_W + ASID_W + 2;
    localparam int CMD_W  = 9;

    // command word bit positions
    localparam int B_SRCH = 8;
    localparam int B_CALL = 7;
    localparam int B_CUNL = 6;
    localparam int B_CASD = 5;
    localparam int B_ISEL = 4;
    localparam int B_ADRS = 3;
    localparam int B_RD   = 2;
    localparam int B_ACC  = 1;
    localparam int B_UPD  = 0;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ASID_W-1:0] asid;
        logic              lock;
        logic              valid;
    } tlb_tag_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_CALL, OP_CUNL, OP_CASD, OP_SRCH, OP_ACC, OP_UPD
    } tlb_op_t;

    typedef enum logic {S_IDLE, S_EXEC} ctl_state_t;
endpackage

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_maint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_unl,
    input  logic              clr_asid,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  tlb_tag_t          wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output tlb_tag_t          rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic [TAG_W-1:0]  probe_tag,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [N_ENT-1:0]  lock_vec
);
    tlb_tag_t          tags [N_ENT];
    logic [DATA_W-1:0] data [N_ENT];
    logic [N_ENT-1:0]  valid_vec;

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (!rst_n || clr_all) begin
                tags[i] <= '0;
            end else if (clr_unl && !tags[i].lock) begin
                tags[i].valid <= 1'b0;
            end else if (clr_asid && !tags[i].lock && tags[i].asid == cur_asid) begin
                tags[i].valid <= 1'b0;
            end else if (wr_en && idx == IDX_W'(i)) begin
                tags[i] <= wr_tag;
            end
            if (!rst_n)
                data[i] <= '0;
            else if (wr_en && idx == IDX_W'(i))
                data[i] <= wr_data;
        end
    end

    assign rd_tag  = tags[idx];
    assign rd_data = data[idx];

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            valid_vec[i] = tags[i].valid;
            lock_vec[i]  = tags[i].lock;
        end
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (tags[i].valid && tags[i].tag == probe_tag && tags[i].asid == cur_asid) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    p_clear_all_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_vec == '0 && lock_vec == '0));
    p_clear_unl_drops_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_unl && !clr_all |=> (valid_vec & ~lock_vec) == '0);
    p_clear_unl_keeps_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_unl && !clr_all |=> (valid_vec & lock_vec) == $past(valid_vec & lock_vec));
    p_clear_asid_keeps_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_asid && !clr_all && !clr_unl |=> (valid_vec & lock_vec) == $past(valid_vec & lock_vec));
endmodule

// File: rtl/rr_victim.sv
module rr_victim
    import tlb_maint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [N_ENT-1:0] lock_vec,
    output logic [IDX_W-1:0] victim,
    output logic             none_free
);
    logic [IDX_W-1:0] ptr;

    always_comb begin
        logic [IDX_W-1:0] cand;
        victim    = ptr;
        none_free = 1'b1;
        for (int k = N_ENT - 1; k >= 0; k--) begin
            cand = IDX_W'((int'(ptr) + k) % N_ENT);
            if (!lock_vec[cand]) begin
                victim    = cand;
                none_free = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ptr <= '0;
        else if (adv && !none_free)
            ptr <= (victim == IDX_W'(N_ENT - 1)) ? '0 : IDX_W'(victim + 1'b1);
    end

    p_all_locked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adv && none_free && !clr |=> $stable(ptr));
    p_ptr_follows_victim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !none_free && !clr |=> ptr != $past(victim));
endmodule

// File: rtl/tlb_maint_ctrl.sv
module tlb_maint_ctrl
    import tlb_maint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    input  logic              ar_we,
    input  logic [TAG_W-1:0]  ar_wdata,
    input  logic              asid_we,
    input  logic [ASID_W-1:0] asid_wdata,
    input  logic              tr_we,
    input  logic [TR_W-1:0]   tr_wdata,
    output logic [TR_W-1:0]   tr_rdata,
    input  logic              dr_we,
    input  logic [DATA_W-1:0] dr_wdata,
    output logic [DATA_W-1:0] dr_rdata,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              srch_hit,
    output logic              done
);
    ctl_state_t        state;
    tlb_op_t           op_q;
    logic              cfg_isel, cfg_adr, cfg_rd;
    logic [TAG_W-1:0]  ar_q;
    logic [ASID_W-1:0] asid_q;
    tlb_tag_t          tr_q;
    logic [DATA_W-1:0] dr_q;
    logic [IDX_W-1:0]  alloc_q;
    logic              hit_q, done_q;

    function automatic tlb_op_t decode(input logic [CMD_W-1:0] c);
        if (c[B_CALL]) return OP_CALL;
        if (c[B_CUNL]) return OP_CUNL;
        if (c[B_CASD]) return OP_CASD;
        if (c[B_SRCH]) return OP_SRCH;
        if (c[B_ACC])  return OP_ACC;
        if (c[B_UPD])  return OP_UPD;
        return OP_NONE;
    endfunction

    logic exec;
    logic [IDX_W-1:0] acc_idx;
    assign exec    = (state == S_EXEC);
    assign acc_idx = cfg_adr ? ar_q[IDX_W-1:0] : alloc_q;

    tlb_tag_t          rd_tag_v   [2];
    logic [DATA_W-1:0] rd_data_v  [2];
    logic              hit_v      [2];
    logic [IDX_W-1:0]  hit_idx_v  [2];
    logic [IDX_W-1:0]  victim_v   [2];
    logic              none_v     [2];

    // index 0: data buffer, index 1: instruction buffer
    for (genvar t = 0; t < 2; t++) begin : g_tlb
        logic             sel_me;
        logic [N_ENT-1:0] locks;
        assign sel_me = (cfg_isel == 1'(t));

        tlb_array u_arr (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_all   (exec && op_q == OP_CALL),
            .clr_unl   (exec && op_q == OP_CUNL),
            .clr_asid  (exec && op_q == OP_CASD),
            .cur_asid  (asid_q),
            .wr_en     (exec && op_q == OP_ACC && !cfg_rd && sel_me),
            .idx       (acc_idx),
            .wr_tag    (tr_q),
            .wr_data   (dr_q),
            .rd_tag    (rd_tag_v[t]),
            .rd_data   (rd_data_v[t]),
            .probe_tag (ar_q),
            .hit       (hit_v[t]),
            .hit_idx   (hit_idx_v[t]),
            .lock_vec  (locks)
        );

        rr_victim u_rr (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (exec && op_q == OP_CALL),
            .adv       (exec && op_q == OP_UPD && sel_me),
            .lock_vec  (locks),
            .victim    (victim_v[t]),
            .none_free (none_v[t])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_NONE;
            cfg_isel <= 1'b0;
            cfg_adr  <= 1'b0;
            cfg_rd   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (cmd_we) begin
                    state    <= S_EXEC;
                    op_q     <= decode(cmd_wdata);
                    cfg_isel <= cmd_wdata[B_ISEL];
                    cfg_adr  <= cmd_wdata[B_ADRS];
                    cfg_rd   <= cmd_wdata[B_RD];
                end
                S_EXEC: state <= S_IDLE;
            endcase
        end
    end

    // outputs and software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q    <= '0;
            asid_q  <= '0;
            tr_q    <= '0;
            dr_q    <= '0;
            alloc_q <= '0;
            hit_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= exec;
            if (ar_we)   ar_q   <= ar_wdata;
            if (asid_we) asid_q <= asid_wdata;
            if (exec && op_q == OP_ACC && cfg_rd) begin
                tr_q <= rd_tag_v[cfg_isel];
                dr_q <= rd_data_v[cfg_isel];
            end else begin
                if (tr_we) tr_q <= tr_wdata;
                if (dr_we) dr_q <= dr_wdata;
            end
            if (exec && op_q == OP_SRCH) begin
                hit_q <= hit_v[cfg_isel];
                if (hit_v[cfg_isel]) alloc_q <= hit_idx_v[cfg_isel];
            end
            if (exec && op_q == OP_UPD && !none_v[cfg_isel])
                alloc_q <= victim_v[cfg_isel];
        end
    end

    assign cmd_rdata = {4'b0, cfg_isel, cfg_adr, cfg_rd, 2'b0};
    assign tr_rdata  = tr_q;
    assign dr_rdata  = dr_q;
    assign alloc_idx = alloc_q;
    assign srch_hit  = hit_q;
    assign done      = done_q;

    p_done_follows_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> done && state == S_IDLE);
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_miss_keeps_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op_q == OP_SRCH && !hit_v[cfg_isel] |=> !srch_hit && $stable(alloc_idx));
    p_hit_loads_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op_q == OP_SRCH && hit_v[cfg_isel] |=> srch_hit && alloc_idx == $past(hit_idx_v[cfg_isel]));
    p_strobes_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && state == S_IDLE |=> cmd_rdata[B_ISEL] == $past(cmd_wdata[B_ISEL]));
endmodule

// File: tb/sim_tlb_maint_ctrl.sv
module sim_tlb_maint_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [8:0]  cmd_wdata = '0;
    logic [8:0]  cmd_rdata;
    logic        ar_we = 1'b0;
    logic [19:0] ar_wdata = '0;
    logic        asid_we = 1'b0;
    logic [7:0]  asid_wdata = '0;
    logic        tr_we = 1'b0;
    logic [29:0] tr_wdata = '0;
    logic [29:0] tr_rdata;
    logic        dr_we = 1'b0;
    logic [23:0] dr_wdata = '0;
    logic [23:0] dr_rdata;
    logic [2:0]  alloc_idx;
    logic        srch_hit;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [8:0] C_SRCH = 9'h100, C_CALL = 9'h080, C_CUNL = 9'h040,
                           C_CASD = 9'h020, C_ISEL = 9'h010, C_ADR  = 9'h008,
                           C_RD   = 9'h004, C_ACC  = 9'h002, C_UPD  = 9'h001;

    tlb_maint_ctrl u0 (.*);

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic logic [29:0] mk(input logic [19:0] tg, input logic [7:0] as,
                                       input logic lk, input logic vl);
        return {tg, as, lk, vl};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_ar(input logic [19:0] v);
        ar_wdata = v; ar_we = 1'b1; @(negedge clk); ar_we = 1'b0;
    endtask

    task automatic put_asid(input logic [7:0] v);
        asid_wdata = v; asid_we = 1'b1; @(negedge clk); asid_we = 1'b0;
    endtask

    // R3: done low in between, high one cycle after execution
    task automatic run_cmd(input logic [8:0] c);
        cmd_wdata = c; cmd_we = 1'b1;
        @(negedge clk); cmd_we = 1'b0;
        chk("R3 done low before exec", 32'(done), 32'd0);
        @(negedge clk);
        chk("R3 done pulse", 32'(done), 32'd1);
    endtask

    task automatic put_entry(input logic sel, input logic [2:0] idx,
                             input logic [29:0] tw, input logic [23:0] dw);
        put_ar(20'(idx));
        tr_wdata = tw; tr_we = 1'b1; dr_wdata = dw; dr_we = 1'b1;
        @(negedge clk); tr_we = 1'b0; dr_we = 1'b0;
        run_cmd((sel ? C_ISEL : 9'h0) | C_ADR | C_ACC);
    endtask

    task automatic get_entry(input logic sel, input logic [2:0] idx,
                             output logic [29:0] tw, output logic [23:0] dw);
        put_ar(20'(idx));
        run_cmd((sel ? C_ISEL : 9'h0) | C_ADR | C_RD | C_ACC);
        tw = tr_rdata; dw = dr_rdata;
    endtask

    task automatic t_reset();
        logic [29:0] tw; logic [23:0] dw;
        chk("R1 alloc_idx", 32'(alloc_idx), 0);
        chk("R1 srch_hit", 32'(srch_hit), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 cmd_rdata", 32'(cmd_rdata), 0);
        get_entry(1'b0, 3'd3, tw, dw);
        chk("R1 dtlb entry tag", 32'(tw), 0);
        get_entry(1'b1, 3'd6, tw, dw);
        chk("R1 itlb entry data", 32'(dw), 0);
    endtask

    task automatic t_cmd_layout();
        run_cmd(C_ISEL | C_ADR | C_RD);
        chk("R2 config readback", 32'(cmd_rdata), 32'h01C);
        @(negedge clk);
        chk("R3 done single cycle", 32'(done), 0);
        run_cmd(C_UPD | C_ACC | C_ISEL);
        chk("R2 strobes read zero", 32'(cmd_rdata), 32'h010);
    endtask

    task automatic t_access();
        logic [29:0] tw; logic [23:0] dw;
        put_entry(1'b0, 3'd5, mk(20'h12345, 8'h11, 1'b0, 1'b1), 24'hABCDE1);
        put_entry(1'b1, 3'd5, mk(20'h54321, 8'h11, 1'b0, 1'b1), 24'h777777);
        get_entry(1'b0, 3'd5, tw, dw);
        chk("R9 read tag by address", 32'(tw), 32'(mk(20'h12345, 8'h11, 1'b0, 1'b1)));
        chk("R9 read data by address", 32'(dw), 32'hABCDE1);
        chk("R8 data buffer untouched by instr write", 32'(dw), 32'hABCDE1);
        get_entry(1'b1, 3'd5, tw, dw);
        chk("R8 instr buffer entry", 32'(dw), 32'h777777);
        // write through allocation index (0)
        tr_wdata = mk(20'h0AAAA, 8'h33, 1'b0, 1'b1); tr_we = 1'b1;
        dr_wdata = 24'h0BEEF0; dr_we = 1'b1;
        @(negedge clk); tr_we = 1'b0; dr_we = 1'b0;
        run_cmd(C_ACC);
        get_entry(1'b0, 3'd0, tw, dw);
        chk("R9 write via alloc index", 32'(dw), 32'h0BEEF0);
        put_ar(20'h00005);
        run_cmd(C_RD | C_ACC);
        chk("R9 read via alloc index ignores ar", 32'(dr_rdata), 32'h0BEEF0);
    endtask

    task automatic t_search();
        put_entry(1'b0, 3'd6, mk(20'h12345, 8'h11, 1'b0, 1'b1), 24'h1);
        put_asid(8'h11);
        put_ar(20'h12345);
        run_cmd(C_SRCH);
        chk("R7 hit flag", 32'(srch_hit), 1);
        chk("R7 lowest matching index", 32'(alloc_idx), 5);
        run_cmd(C_SRCH | C_ISEL);
        chk("R8 instr buffer search misses", 32'(srch_hit), 0);
        chk("R7 miss keeps alloc", 32'(alloc_idx), 5);
        run_cmd(C_SRCH);
        put_asid(8'h22);
        run_cmd(C_SRCH);
        chk("R7 asid mismatch misses", 32'(srch_hit), 0);
        put_ar(20'h54321);
        run_cmd(C_SRCH | C_ISEL);
        chk("R7 ASID mismatch in instr buffer", 32'(srch_hit), 0);
        put_asid(8'h11);
        run_cmd(C_SRCH | C_ISEL);
        chk("R8 instr buffer search hit", 32'(srch_hit), 1);
    endtask

    task automatic t_update();
        logic [2:0] exp_seq [6] = '{3'd2, 3'd4, 3'd5, 3'd6, 3'd7, 3'd2};
        run_cmd(C_CALL);
        put_entry(1'b0, 3'd0, mk(20'h1, 8'h0, 1'b1, 1'b1), 24'h0);
        put_entry(1'b0, 3'd1, mk(20'h2, 8'h0, 1'b1, 1'b1), 24'h0);
        put_entry(1'b0, 3'd3, mk(20'h3, 8'h0, 1'b1, 1'b1), 24'h0);
        for (int i = 0; i < 6; i++) begin
            run_cmd(C_UPD);
            chk("R10 round robin skips locked", 32'(alloc_idx), 32'(exp_seq[i]));
        end
        run_cmd(C_UPD | C_ISEL);
        chk("R10 instr pointer independent", 32'(alloc_idx), 0);
        for (int i = 0; i < 8; i++)
            put_entry(1'b1, 3'(i), mk(20'(i + 16), 8'h0, 1'b1, 1'b1), 24'h0);
        run_cmd(C_UPD);
        chk("R10 data buffer continues", 32'(alloc_idx), 4);
        run_cmd(C_UPD | C_ISEL);
        chk("R10 all locked leaves alloc", 32'(alloc_idx), 4);
    endtask

    task automatic t_clears();
        logic [29:0] tw; logic [23:0] dw;
        for (int i = 0; i < 8; i++)
            put_entry(1'b0, 3'(i), mk(20'(256 + i), (i % 2 == 0) ? 8'h11 : 8'h22,
                      1'(i < 2), 1'b1), 24'(i));
        put_asid(8'h11);
        run_cmd(C_CASD);
        for (int i = 0; i < 8; i++) begin
            get_entry(1'b0, 3'(i), tw, dw);
            chk("R6 clear by ASID valid bit", 32'(tw[0]), 32'(!(i % 2 == 0 && i >= 2)));
        end
        run_cmd(C_CUNL);
        for (int i = 0; i < 8; i++) begin
            get_entry(1'b0, 3'(i), tw, dw);
            chk("R5 clear unlocked valid bit", 32'(tw[0]), 32'(i < 2));
        end
        get_entry(1'b1, 3'd7, tw, dw);
        chk("R5 locked instr entry kept", 32'(tw), 32'(mk(20'd23, 8'h0, 1'b1, 1'b1)));
        run_cmd(C_CALL | C_ISEL);
        get_entry(1'b0, 3'd0, tw, dw);
        chk("R4 locked data entry cleared", 32'(tw), 0);
        get_entry(1'b1, 3'd7, tw, dw);
        chk("R4 locked instr entry cleared", 32'(tw), 0);
        run_cmd(C_UPD);
        chk("R4 pointer reset", 32'(alloc_idx), 0);
    endtask

    task automatic t_priority();
        logic [29:0] tw; logic [23:0] dw;
        put_asid(8'h11);
        put_entry(1'b0, 3'd4, mk(20'h00ABC, 8'h11, 1'b1, 1'b1), 24'h44);
        put_entry(1'b0, 3'd2, mk(20'h00777, 8'h11, 1'b0, 1'b1), 24'h22);
        put_ar(20'h00777);
        run_cmd(C_SRCH);
        chk("R7 search hit index", 32'(alloc_idx), 2);
        put_ar(20'h00999);
        run_cmd(C_CUNL | C_SRCH | C_UPD);
        chk("R11 clear wins, hit kept", 32'(srch_hit), 1);
        chk("R11 clear wins, alloc kept", 32'(alloc_idx), 2);
        get_entry(1'b0, 3'd2, tw, dw);
        chk("R11 clear executed", 32'(tw[0]), 0);
        put_ar(20'h00ABC);
        run_cmd(C_SRCH | C_ACC | C_UPD | C_RD | C_ADR);
        chk("R11 search wins over access", 32'(alloc_idx), 4);
        chk("R11 access skipped", 32'(dr_rdata), 32'h22);
        run_cmd(C_ACC | C_UPD | C_RD | C_ADR);
        chk("R11 access wins over update", 32'(dr_rdata), 32'h44);
        chk("R11 update skipped", 32'(alloc_idx), 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_layout();
        t_access();
        t_search();
        t_update();
        t_clears();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule